// File: doc/BRIEF.md
# Operand-2 Barrel Shifter

This combinational unit builds the second ALU operand of a data-processing datapath, together with the shifter carry-out that feeds the carry flag on flag-setting operations. It takes a 12-bit operand field, a select bit that marks the field as an immediate, the value already read from the operand register, the low byte of the shift-amount register and the current carry flag. The register file, the extra cycle needed to read a shift-amount register, and the ALU are outside the block.

With the immediate select set, the field holds an 8-bit constant and a 4-bit rotate count, and the operand is the constant rotated right by twice that count. With the select clear, bit 4 of the field chooses where the shift amount comes from: a 5-bit amount inside the field, or the low byte of a register. The four shift kinds are logical left, logical right, arithmetic right and rotate right. Some zero amounts in the field have a special meaning: a right shift by zero means a shift by the full word, and a rotate by zero means a one-bit rotate through the carry flag.

Top module: `op2_barrel_shifter`

## Requirements
- R1: With `imm_sel`=1, `op2_val` is the zero-extended `op2_field[7:0]` rotated right by 2×`op2_field[11:8]` bit positions.
- R2: With `imm_sel`=1, `carry_out` equals `carry_in` when `op2_field[11:8]` is zero and equals bit 31 of `op2_val` otherwise.
- R3: With `imm_sel`=0, `op2_field[6:5]` selects the shift kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). `op2_field[4]`=0 takes the amount from `op2_field[11:7]`; `op2_field[4]`=1 takes it from `rs_low`, and then `op2_field[11:7]` and `op2_field[3:0]` have no effect.
- R4: Logical left by n in 1..31 gives `rm_val`<<n with carry = `rm_val`[32−n]. A field amount of zero with logical left passes `rm_val` and `carry_in` through.
- R5: Logical right by n in 1..31 gives `rm_val`>>n with carry = `rm_val`[n−1]. A field amount of zero means a shift by 32 and gives 0 with carry = `rm_val`[31].
- R6: Arithmetic right fills with `rm_val`[31]. For n in 1..31 the carry is `rm_val`[n−1]. A field amount of zero means a shift by 32 and gives all bits and the carry equal to `rm_val`[31].
- R7: Rotate right by n in 1..31 wraps the low bits into the top, with carry = `rm_val`[n−1], the last bit rotated out.
- R8: Rotate right with a field amount of zero is a one-bit rotate through carry: `op2_val` = {`carry_in`, `rm_val`[31:1]} and carry = `rm_val`[0].
- R9: A register amount of zero leaves `rm_val` and `carry_in` unchanged for every shift kind.
- R10: A register amount of exactly 32 gives 0 for logical shifts, with carry = `rm_val`[0] for left and `rm_val`[31] for right. Register amounts above 32 give 0 with carry 0.
- R11: A register amount of 32 or more with arithmetic right gives all bits and the carry equal to `rm_val`[31].
- R12: Rotate right by a register amount uses the amount modulo 32. A non-zero multiple of 32 leaves the value unchanged with carry = `rm_val`[31].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op2_field | input | 12 | Operand field: constant and rotate count, or the shift descriptor |
| imm_sel | input | 1 | 1 = rotated-constant form, 0 = shifted-register form |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_low | input | 8 | Low byte of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| op2_val | output | 32 | Formed second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the amount boundaries where each shift kind changes rule: 0, 1, 31, 32, 33 and 255 from the register, and zero from the field. A design that treated a field zero as a plain zero would pass the value through where the right shifts must clear it or fill it with the sign, and would give a zero-bit rotate where a rotate through carry is expected. A design that wrapped or truncated large register amounts would return shifted data where zero or a sign fill is required, or the wrong carry at exactly 32. The bench also checks the carry source of the rotated constant at a count of zero and above, and that the unused field bits in the register-amount form have no effect on the outputs.

// File: rtl/op2_shift_pkg.sv
package op2_shift_pkg;

   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;

   localparam int unsigned FIELD_W = 12;

endpackage

// File: rtl/op2_rotr.sv
// Logarithmic right rotator: one stage per amount bit.
module op2_rotr #(
   parameter int unsigned W  = 32,
   parameter int unsigned AW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);

   generate
      if ((W & (W - 1)) != 0 || W < 2) begin : g_bad_w
         $error("op2_rotr: W must be a power of two of at least 2");
      end
      if ((1 << AW) != W) begin : g_bad_aw
         $error("op2_rotr: AW must equal log2(W)");
      end
   endgenerate

   logic [W-1:0] stg [0:AW];

   assign stg[0] = din;

   generate
      for (genvar s = 0; s < AW; s++) begin : g_stage
         localparam int unsigned K = 1 << s;
         assign stg[s+1] = amt[s] ? {stg[s][K-1:0], stg[s][W-1:K]} : stg[s];
      end
   endgenerate

   assign dout = stg[AW];

endmodule

// File: rtl/op2_imm_expand.sv
// Rotated-constant form of the second operand.
module op2_imm_expand #(
   parameter int unsigned W     = 32,
   parameter int unsigned IMM_W = 8,
   parameter int unsigned ROT_W = 4,
   localparam int unsigned AW   = $clog2(W)
) (
   input  logic [ROT_W-1:0] rot,
   input  logic [IMM_W-1:0] imm,
   input  logic             cin,
   output logic [W-1:0]     val,
   output logic             cout
);

   generate
      if (IMM_W > W) begin : g_bad_imm
         $error("op2_imm_expand: IMM_W must not exceed W");
      end
      if (ROT_W + 1 > AW) begin : g_bad_rot
         $error("op2_imm_expand: twice the largest rotate must stay below W");
      end
   endgenerate

   logic [W-1:0]  imm_ext;
   logic [AW-1:0] rot_amt;

   assign imm_ext = W'(imm);
   assign rot_amt = AW'({rot, 1'b0});

   op2_rotr #(.W(W), .AW(AW)) u_rot (
      .din  (imm_ext),
      .amt  (rot_amt),
      .dout (val)
   );

   assign cout = (rot == '0) ? cin : val[W-1];

   always_comb begin
      // R1
      imm_pop_chk: assert ($countones(val) == $countones(imm))
         else $error("rotated constant lost or gained bits");
      // R2
      imm_carry_chk: assert (!cout || (rot == '0) || (val != '0))
         else $error("carry set from an all-zero rotated constant");
   end

endmodule

// File: rtl/op2_shift_core.sv
// Register shift: four kinds, field or register amount, special zero amounts.
module op2_shift_core
   import op2_shift_pkg::*;
#(
   parameter int unsigned W     = 32,
   parameter int unsigned AMT_W = 8,
   localparam int unsigned AW   = $clog2(W)
) (
   input  logic [W-1:0]     val,
   input  shift_kind_e      kind,
   input  logic [AMT_W-1:0] amt,
   input  logic             amt_from_reg,
   input  logic             cin,
   output logic [W-1:0]     dout,
   output logic             cout
);

   generate
      if ((W & (W - 1)) != 0 || W < 2) begin : g_bad_w
         $error("op2_shift_core: W must be a power of two of at least 2");
      end
      if (AMT_W < AW + 1) begin : g_bad_amt
         $error("op2_shift_core: AMT_W must hold the full word width");
      end
   endgenerate

   localparam logic [AMT_W:0] FULL = (AMT_W+1)'(W);

   logic [AMT_W:0] n;
   logic           pass_thru;
   logic           rrx;
   logic [W:0]     lsl_t;
   logic [W:0]     lsr_t;
   logic [W:0]     asr_t;
   logic [AMT_W:0] asr_n;
   logic [W-1:0]   ror_v;

   // Amount normalisation.
   always_comb begin
      n         = {1'b0, amt};
      pass_thru = 1'b0;
      rrx       = 1'b0;
      if (amt == '0) begin
         if (amt_from_reg) begin
            pass_thru = 1'b1;
         end else begin
            unique case (kind)
               SK_LSL:         pass_thru = 1'b1;
               SK_LSR, SK_ASR: n         = FULL;
               SK_ROR:         rrx       = 1'b1;
               default:        pass_thru = 1'b1;
            endcase
         end
      end
   end

   assign lsl_t = {1'b0, val} << n;
   assign lsr_t = {val, 1'b0} >> n;
   assign asr_n = (n > FULL) ? FULL : n;
   assign asr_t = $signed({val, 1'b0}) >>> asr_n;

   op2_rotr #(.W(W), .AW(AW)) u_ror (
      .din  (val),
      .amt  (n[AW-1:0]),
      .dout (ror_v)
   );

   always_comb begin
      dout = val;
      cout = cin;
      if (rrx) begin
         dout = {cin, val[W-1:1]};
         cout = val[0];
      end else if (!pass_thru) begin
         unique case (kind)
            SK_LSL: begin
               dout = (n > FULL) ? '0 : lsl_t[W-1:0];
               cout = (n > FULL) ? 1'b0 : lsl_t[W];
            end
            SK_LSR: begin
               dout = (n > FULL) ? '0 : lsr_t[W:1];
               cout = (n > FULL) ? 1'b0 : lsr_t[0];
            end
            SK_ASR: begin
               dout = asr_t[W:1];
               cout = asr_t[0];
            end
            SK_ROR: begin
               dout = ror_v;
               cout = ror_v[W-1];
            end
            default: begin
               dout = val;
               cout = cin;
            end
         endcase
      end
   end

   always_comb begin
      // R8
      rrx_in_chk: assert (!(!amt_from_reg && kind == SK_ROR && amt == '0)
                          || (dout[W-1] == cin && cout == val[0]))
         else $error("rotate through carry misformed");
      // R9
      reg_zero_chk: assert (!(amt_from_reg && amt == '0)
                            || (dout == val && cout == cin))
         else $error("zero register amount altered the operand");
      // R10
      lsl_big_chk: assert (!(amt_from_reg && kind == SK_LSL && {1'b0, amt} > FULL)
                           || (dout == '0 && !cout))
         else $error("oversized logical shift left not cleared");
      // R11
      asr_fill_chk: assert (!(amt_from_reg && kind == SK_ASR && {1'b0, amt} >= FULL)
                            || ($countones(dout) == (val[W-1] ? W : 0) && cout == val[W-1]))
         else $error("oversized arithmetic shift not sign filled");
      // R12
      ror_pop_chk: assert (!(kind == SK_ROR && amt != '0)
                           || $countones(dout) == $countones(val))
         else $error("rotate changed the number of set bits");
   end

endmodule

// File: rtl/op2_barrel_shifter.sv
// Top: decodes the operand field and selects constant or shifted register.
module op2_barrel_shifter
   import op2_shift_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RS_W   = 8
) (
   input  logic [11:0]       op2_field,
   input  logic              imm_sel,
   input  logic [DATA_W-1:0] rm_val,
   input  logic [RS_W-1:0]   rs_low,
   input  logic              carry_in,
   output logic [DATA_W-1:0] op2_val,
   output logic              carry_out
);

   localparam int unsigned FAMT_W = 5;

   generate
      if (FIELD_W != 12) begin : g_bad_field
         $error("op2_barrel_shifter: field layout assumes 12 bits");
      end
      if (DATA_W != (1 << FAMT_W)) begin : g_bad_data
         $error("op2_barrel_shifter: field amount width needs DATA_W of 32");
      end
   endgenerate

   logic [DATA_W-1:0] imm_v;
   logic              imm_c;
   logic [DATA_W-1:0] sh_v;
   logic              sh_c;
   logic              amt_from_reg;
   logic [RS_W-1:0]   sh_amt;
   shift_kind_e       kind;

   assign amt_from_reg = op2_field[4];
   assign kind         = shift_kind_e'(op2_field[6:5]);
   assign sh_amt       = amt_from_reg ? rs_low : RS_W'(op2_field[11:7]);

   op2_imm_expand #(.W(DATA_W), .IMM_W(8), .ROT_W(4)) u_imm (
      .rot  (op2_field[11:8]),
      .imm  (op2_field[7:0]),
      .cin  (carry_in),
      .val  (imm_v),
      .cout (imm_c)
   );

   op2_shift_core #(.W(DATA_W), .AMT_W(RS_W)) u_shift (
      .val          (rm_val),
      .kind         (kind),
      .amt          (sh_amt),
      .amt_from_reg (amt_from_reg),
      .cin          (carry_in),
      .dout         (sh_v),
      .cout         (sh_c)
   );

   assign op2_val   = imm_sel ? imm_v : sh_v;
   assign carry_out = imm_sel ? imm_c : sh_c;

   always_comb begin
      // R2
      imm_c_hold_chk: assert (!(imm_sel && op2_field[11:8] == 4'd0)
                              || carry_out == carry_in)
         else $error("unrotated constant changed the carry");
      // R3
      rm_idx_known_chk: assert (!$isunknown(op2_field[3:0]))
         else $error("register index bits unknown");
      // R4
      lsl0_chk: assert (!(!imm_sel && op2_field[11:4] == 8'd0)
                        || (op2_val == rm_val && carry_out == carry_in))
         else $error("logical left by zero altered the operand");
   end

endmodule

// File: tb/op2_barrel_shifter_tb_top.sv
module op2_barrel_shifter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] op2_field = '0;
   logic        imm_sel = 1'b0;
   logic [31:0] rm_val = '0;
   logic [7:0]  rs_low = '0;
   logic        carry_in = 1'b0;
   logic [31:0] op2_val;
   logic        carry_out;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   op2_barrel_shifter dut_i (
      .op2_field (op2_field),
      .imm_sel   (imm_sel),
      .rm_val    (rm_val),
      .rs_low    (rs_low),
      .carry_in  (carry_in),
      .op2_val   (op2_val),
      .carry_out (carry_out)
   );

   // Expected result from the requirements, bit by bit: {carry, value}.
   function automatic logic [32:0] expect_op2(input logic [11:0] f, input logic im,
                                              input logic [31:0] v, input logic [7:0] rs,
                                              input logic c);
      logic [31:0] r;
      logic        co;
      int          n;
      int          k;
      r  = v;
      co = c;
      if (im) begin
         k = 2 * int'(f[11:8]);
         for (int i = 0; i < 32; i++) r[i] = (((i + k) % 32) < 8) ? f[(i + k) % 32] : 1'b0;
         co = (k == 0) ? c : r[31];
         return {co, r};
      end
      n = f[4] ? int'(rs) : int'(f[11:7]);
      if (n == 0) begin
         if (f[4] || f[6:5] == 2'b00) return {c, v};
         if (f[6:5] == 2'b11) return {v[0], c, v[31:1]};
         n = 32;
      end
      case (f[6:5])
         2'b00: begin
            for (int i = 0; i < 32; i++) r[i] = (i >= n) ? v[i - n] : 1'b0;
            co = (n <= 32) ? v[32 - n] : 1'b0;
         end
         2'b01: begin
            for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i + n] : 1'b0;
            co = (n <= 32) ? v[n - 1] : 1'b0;
         end
         2'b10: begin
            for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i + n] : v[31];
            co = (n <= 32) ? v[n - 1] : v[31];
         end
         default: begin
            k = n % 32;
            for (int i = 0; i < 32; i++) r[i] = v[(i + k) % 32];
            co = v[(k + 31) % 32];
         end
      endcase
      return {co, r};
   endfunction

   task automatic apply_check(input string tag, input logic [11:0] f, input logic im,
                              input logic [31:0] v, input logic [7:0] rs, input logic c);
      logic [32:0] exp_v;
      @(negedge clk);
      op2_field = f;
      imm_sel   = im;
      rm_val    = v;
      rs_low    = rs;
      carry_in  = c;
      #1;
      exp_v = expect_op2(f, im, v, rs, c);
      n_checks++;
      if ({carry_out, op2_val} !== exp_v) begin
         n_errors++;
         $display("FAIL %s: field=%h imm=%0b rm=%h rs=%0d c=%0b actual c=%0b v=%h expected c=%0b v=%h",
                  tag, f, im, v, rs, c, carry_out, op2_val, exp_v[32], exp_v[31:0]);
      end
   endtask

   function automatic logic [11:0] fld_imm(input logic [3:0] rot, input logic [7:0] k);
      return {rot, k};
   endfunction

   function automatic logic [11:0] fld_fix(input logic [4:0] a, input logic [1:0] t);
      return {a, t, 1'b0, 4'd2};
   endfunction

   function automatic logic [11:0] fld_reg(input logic [1:0] t);
      return {4'd3, 1'b0, t, 1'b1, 4'd2};
   endfunction

   task automatic t_reset_state();
      // R4: all-zero inputs are a logical left by zero: zero out, zero carry
      @(negedge clk);
      n_checks++;
      if (op2_val !== 32'd0 || carry_out !== 1'b0) begin
         n_errors++;
         $display("FAIL R4 reset: actual c=%0b v=%h expected c=0 v=00000000", carry_out, op2_val);
      end
   endtask

   task automatic t_immediate();
      // R1 R2
      apply_check("R2", fld_imm(4'd0, 8'hA5), 1'b1, 32'h0, 8'd0, 1'b1);
      apply_check("R2", fld_imm(4'd0, 8'hFF), 1'b1, 32'h0, 8'd0, 1'b0);
      apply_check("R1", fld_imm(4'd1, 8'h03), 1'b1, 32'h0, 8'd0, 1'b0);
      apply_check("R1", fld_imm(4'd4, 8'hAB), 1'b1, 32'h0, 8'd0, 1'b1);
      apply_check("R2", fld_imm(4'd15, 8'h81), 1'b1, 32'h0, 8'd0, 1'b0);
      apply_check("R2", fld_imm(4'd12, 8'h7F), 1'b1, 32'h0, 8'd0, 1'b1);
   endtask

   task automatic t_field_shifts();
      apply_check("R4", fld_fix(5'd0,  2'b00), 1'b0, 32'h8000_0001, 8'd0, 1'b1);
      apply_check("R4", fld_fix(5'd1,  2'b00), 1'b0, 32'h8000_0001, 8'd0, 1'b0);
      apply_check("R4", fld_fix(5'd31, 2'b00), 1'b0, 32'h0000_0003, 8'd0, 1'b0);
      apply_check("R5", fld_fix(5'd4,  2'b01), 1'b0, 32'hF000_0018, 8'd0, 1'b0);
      apply_check("R5", fld_fix(5'd0,  2'b01), 1'b0, 32'h8765_4321, 8'd0, 1'b0);
      apply_check("R6", fld_fix(5'd3,  2'b10), 1'b0, 32'h8000_0004, 8'd0, 1'b0);
      apply_check("R6", fld_fix(5'd0,  2'b10), 1'b0, 32'h9000_0000, 8'd0, 1'b0);
      apply_check("R6", fld_fix(5'd0,  2'b10), 1'b0, 32'h7FFF_FFFF, 8'd0, 1'b1);
      apply_check("R7", fld_fix(5'd8,  2'b11), 1'b0, 32'h1234_5680, 8'd0, 1'b0);
      apply_check("R7", fld_fix(5'd1,  2'b11), 1'b0, 32'h0000_0001, 8'd0, 1'b0);
   endtask

   task automatic t_rrx();
      apply_check("R8", fld_fix(5'd0, 2'b11), 1'b0, 32'h0000_0003, 8'd0, 1'b1);
      apply_check("R8", fld_fix(5'd0, 2'b11), 1'b0, 32'hFFFF_FFFE, 8'd0, 1'b0);
   endtask

   task automatic t_reg_amounts();
      logic [7:0] amts [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
      for (int t = 0; t < 4; t++) begin
         for (int a = 0; a < 6; a++) begin
            string tag;
            if (amts[a] == 8'd0)        tag = "R9";
            else if (amts[a] < 8'd32)   tag = (t == 0) ? "R4" : (t == 1) ? "R5" : (t == 2) ? "R6" : "R7";
            else if (t == 2)            tag = "R11";
            else if (t == 3)            tag = "R12";
            else                        tag = "R10";
            apply_check(tag, fld_reg(2'(t)), 1'b0, 32'hC000_0001, amts[a], 1'b1);
            apply_check(tag, fld_reg(2'(t)), 1'b0, 32'h4000_8002, amts[a], 1'b0);
         end
      end
      apply_check("R12", fld_reg(2'b11), 1'b0, 32'h0000_00F1, 8'd36, 1'b0);
      apply_check("R12", fld_reg(2'b11), 1'b0, 32'h8000_0000, 8'd64, 1'b0);
   endtask

   task automatic t_ignored_bits();
      logic [32:0] first;
      // R3: register-amount form ignores bits 11:7 and 3:0 of the field
      apply_check("R3", 12'h0_3_3, 1'b0, 32'h1357_9BDF, 8'd5, 1'b0);
      first = {carry_out, op2_val};
      apply_check("R3", 12'hF_B_D, 1'b0, 32'h1357_9BDF, 8'd5, 1'b0);
      n_checks++;
      if ({carry_out, op2_val} !== first) begin
         n_errors++;
         $display("FAIL R3 ignored bits: actual %h expected %h", {carry_out, op2_val}, first);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin : main
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_immediate();
      t_field_shifts();
      t_rrx();
      t_reg_amounts();
      t_ignored_bits();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule